// File: doc/BRIEF.md
# Sector Erase Batcher and Status Generator

This block sits between the command decoder of a byte-wide flash array and its read path. It turns decoded command pulses into the lifetime of an embedded program or erase. A sector-erase request does not start an erase at once. It opens a quiet window, and every further sector-erase request inside that window adds its sector to a mask and restarts the window. The erase of the collected sectors begins only when the window runs out with no new request. A chip-erase request skips the window and erases every sector.

While any operation is active, a read strobe returns a status byte instead of array data. Bit 7 polls data, bit 6 toggles on each read, bit 5 flags a time-limit fault, and bit 3 tells whether the erase has actually begun. Completion returns the block to read mode. A fault holds the block busy until a reset command arrives. The window length and the modelled program and erase durations are parameters counted in clock cycles. A separate fault input stands for the time-limit signal of the algorithm.

Top module: `erase_status_ctrl`

## Requirements
- R1: After reset the block is in read mode, `busy` is 0, `sect_mask` is 0 and `stat_vld` is 0.
- R2: In read mode a sector-erase request opens the acceptance window and loads a mask with only bit `sect_sel` set. The erase starts after WIN_CYC consecutive window cycles with no further request.
- R3: Inside the window, each sector-erase request ORs bit `sect_sel` into the mask and restarts the WIN_CYC count. Sectors may arrive in any order and in any combination.
- R4: Inside the window, any program, chip-erase, reset or other command cancels the batch. The block returns to read mode with an empty mask, and the command itself does not start.
- R5: An erase lasts ERASE_CYC cycles and then returns to read mode with the mask cleared. A chip-erase request in read mode starts the erase at once with all mask bits set.
- R6: While a program or erase runs, every command input (including reset) is ignored. `busy` stays 1 and the mask is unchanged.
- R7: A program request lasts PGM_CYC cycles. Its status bit 7 is the complement of `pgm_msb`, the most significant bit of the byte being written.
- R8: Status bit 3 is 0 during the window and 1 once the erase has begun. Bit 7 is 0 during window and erase. Bits 4, 2, 1 and 0 are always 0.
- R9: Status bit 6 is 0 on the first status read after leaving read mode and inverts on every later status read of the same operation.
- R10: A fault pulse during program or erase sets status bit 5. The block then stays busy and ignores every command except reset, which returns it to read mode with the mask cleared. Bits 7 and 3 keep their values from the faulted operation.
- R11: A read strobe in a busy cycle makes `stat_vld` 1 in the next cycle, with the status of that busy cycle on `stat_byte`. In every other cycle `stat_vld` and `stat_byte` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pgm_req | input | 1 | Program command accepted (one-cycle pulse) |
| pgm_msb | input | 1 | Bit 7 of the byte being programmed, valid with `pgm_req` |
| chip_erase_req | input | 1 | Chip-erase command accepted (pulse) |
| sect_erase_req | input | 1 | Sector-erase command accepted (pulse) |
| sect_sel | input | SECT_W | Sector number carried by `sect_erase_req` |
| other_cmd | input | 1 | Any other command write (pulse) |
| abort_req | input | 1 | Reset command (pulse) |
| alg_fault | input | 1 | Modelled algorithm exceeded its time limit (pulse) |
| rd_stb | input | 1 | Read strobe |
| stat_byte | output | 8 | Status byte, valid with `stat_vld` |
| stat_vld | output | 1 | Status byte returned for the previous read |
| busy | output | 1 | Window, program, erase or fault active |
| sect_mask | output | NUM_SECT | Sectors gathered for or under erase |
| read_mode | output | 1 | Reads return true array data |

## Verification
The assertions assume that the decoder raises at most one command pulse per cycle and that each pulse lasts one cycle. They also assume that `alg_fault` appears only as a single pulse. The stimulus keeps to this: each pulse comes from its own task that raises one input for a single clock and clears it again. No two command tasks ever overlap. Read strobes are likewise one-cycle pulses, driven by their own task.

// File: rtl/erase_stat_pkg.sv
package erase_stat_pkg;
  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_WIN   = 3'd1,
    ST_ERASE = 3'd2,
    ST_PROG  = 3'd3,
    ST_FAULT = 3'd4
  } esg_state_e;

  // status bit positions
  localparam int unsigned POLL_BIT  = 7;
  localparam int unsigned TOG_BIT   = 6;
  localparam int unsigned LIMIT_BIT = 5;
  localparam int unsigned WIN_BIT   = 3;
endpackage

// File: rtl/esg_sequencer.sv
module esg_sequencer
  import erase_stat_pkg::*;
#(
  parameter int unsigned NUM_SECT  = 8,
  parameter int unsigned SECT_W    = 3,
  parameter int unsigned WIN_CYC   = 200,
  parameter int unsigned PGM_CYC   = 16,
  parameter int unsigned ERASE_CYC = 400
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pgm_req,
  input  logic                pgm_msb,
  input  logic                chip_req,
  input  logic                sect_req,
  input  logic [SECT_W-1:0]   sect_sel,
  input  logic                other_cmd,
  input  logic                abort_req,
  input  logic                alg_fault,
  output esg_state_e          state_o,
  output logic [NUM_SECT-1:0] mask_o,
  output logic                d7_o,
  output logic                op_erase_o
);
  localparam int unsigned MAX_A = (WIN_CYC > PGM_CYC) ? WIN_CYC : PGM_CYC;
  localparam int unsigned MAX_C = (MAX_A > ERASE_CYC) ? MAX_A : ERASE_CYC;
  localparam int unsigned CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] WIN_LAST   = CNT_W'(WIN_CYC - 1);
  localparam logic [CNT_W-1:0] PGM_LAST   = CNT_W'(PGM_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYC - 1);

  esg_state_e          st, st_n;
  logic [CNT_W-1:0]    cnt, cnt_n;
  logic [NUM_SECT-1:0] mask, mask_n, sel_dec;
  logic                d7, ope, ope_n, ld_d7, cancel;

  // one-hot decode of the requested sector
  genvar g;
  generate
    for (g = 0; g < NUM_SECT; g++) begin : g_dec
      assign sel_dec[g] = (sect_sel == SECT_W'(g));
    end
  endgenerate

  assign cancel = other_cmd | pgm_req | chip_req | abort_req;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    mask_n = mask;
    ope_n  = ope;
    ld_d7  = 1'b0;
    case (st)
      ST_READ: begin
        if (pgm_req) begin
          st_n = ST_PROG; cnt_n = '0; ld_d7 = 1'b1; ope_n = 1'b0;
        end else if (chip_req) begin
          st_n = ST_ERASE; cnt_n = '0; mask_n = '1; ope_n = 1'b1;
        end else if (sect_req) begin
          st_n = ST_WIN; cnt_n = '0; mask_n = sel_dec; ope_n = 1'b1;
        end
      end
      ST_WIN: begin
        if (cancel) begin
          st_n = ST_READ; cnt_n = '0; mask_n = '0;
        end else if (sect_req) begin
          cnt_n = '0; mask_n = mask | sel_dec;
        end else if (cnt == WIN_LAST) begin
          st_n = ST_ERASE; cnt_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_ERASE: begin
        if (alg_fault) begin
          st_n = ST_FAULT;
        end else if (cnt == ERASE_LAST) begin
          st_n = ST_READ; cnt_n = '0; mask_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_PROG: begin
        if (alg_fault) begin
          st_n = ST_FAULT;
        end else if (cnt == PGM_LAST) begin
          st_n = ST_READ; cnt_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_FAULT: begin
        if (abort_req) begin
          st_n = ST_READ; cnt_n = '0; mask_n = '0;
        end
      end
      default: begin
        st_n = ST_READ; cnt_n = '0; mask_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_READ;
      cnt  <= '0;
      mask <= '0;
      ope  <= 1'b0;
      d7   <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      mask <= mask_n;
      ope  <= ope_n;
      if (ld_d7) d7 <= pgm_msb;
    end
  end

  assign state_o    = st;
  assign mask_o     = mask;
  assign d7_o       = d7;
  assign op_erase_o = ope;

  // R3
  mask_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WIN && sect_req && !cancel) |=> ((mask & $past(mask)) == $past(mask)));
  // R4
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WIN && cancel) |=> (st == ST_READ && mask == '0));
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERASE && !alg_fault && cnt != ERASE_LAST) |=> (st == ST_ERASE && $stable(mask)));
  // R5
  erase_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERASE) |-> (mask != '0));
  // R10
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAULT && !abort_req) |=> (st == ST_FAULT));
endmodule

// File: rtl/esg_status.sv
module esg_status
  import erase_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  esg_state_e st,
  input  logic       d7,
  input  logic       op_erase,
  input  logic       rd_stb,
  output logic [7:0] stat_byte,
  output logic       stat_vld,
  output logic       busy
);
  logic       tog, tog_n, vld_n, rd_hit;
  logic [7:0] rsp, stat_n;

  assign busy   = (st != ST_READ);
  assign rd_hit = rd_stb & busy;

  always_comb begin
    rsp            = 8'h00;
    rsp[POLL_BIT]  = (st == ST_PROG || (st == ST_FAULT && !op_erase)) ? ~d7 : 1'b0;
    rsp[TOG_BIT]   = tog;
    rsp[LIMIT_BIT] = (st == ST_FAULT);
    rsp[WIN_BIT]   = (st == ST_ERASE) || (st == ST_FAULT && op_erase);
    tog_n  = busy ? (rd_stb ? ~tog : tog) : 1'b0;
    stat_n = rd_hit ? rsp : 8'h00;
    vld_n  = rd_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog       <= 1'b0;
      stat_byte <= 8'h00;
      stat_vld  <= 1'b0;
    end else begin
      tog       <= tog_n;
      stat_byte <= stat_n;
      stat_vld  <= vld_n;
    end
  end

  // R11
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy) |=> stat_vld);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb || !busy) |=> (!stat_vld && stat_byte == 8'h00));
  // R9
  tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy && $past(rd_stb) && $past(busy)) |=> (stat_byte[TOG_BIT] != $past(stat_byte[TOG_BIT])));
  // R8
  win_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && stat_byte[WIN_BIT]) |-> !stat_byte[POLL_BIT]);
endmodule

// File: rtl/erase_status_ctrl.sv
module erase_status_ctrl
  import erase_stat_pkg::*;
#(
  parameter int unsigned NUM_SECT  = 8,
  parameter int unsigned SECT_W    = $clog2(NUM_SECT),
  parameter int unsigned WIN_CYC   = 200,
  parameter int unsigned PGM_CYC   = 16,
  parameter int unsigned ERASE_CYC = 400
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pgm_req,
  input  logic                pgm_msb,
  input  logic                chip_erase_req,
  input  logic                sect_erase_req,
  input  logic [SECT_W-1:0]   sect_sel,
  input  logic                other_cmd,
  input  logic                abort_req,
  input  logic                alg_fault,
  input  logic                rd_stb,
  output logic [7:0]          stat_byte,
  output logic                stat_vld,
  output logic                busy,
  output logic [NUM_SECT-1:0] sect_mask,
  output logic                read_mode
);
  esg_state_e st;
  logic       d7, op_erase;

  esg_sequencer #(
    .NUM_SECT(NUM_SECT), .SECT_W(SECT_W), .WIN_CYC(WIN_CYC),
    .PGM_CYC(PGM_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .pgm_req(pgm_req), .pgm_msb(pgm_msb),
    .chip_req(chip_erase_req), .sect_req(sect_erase_req), .sect_sel(sect_sel),
    .other_cmd(other_cmd), .abort_req(abort_req), .alg_fault(alg_fault),
    .state_o(st), .mask_o(sect_mask), .d7_o(d7), .op_erase_o(op_erase)
  );

  esg_status u_stat (
    .clk(clk), .rst_n(rst_n), .st(st), .d7(d7), .op_erase(op_erase),
    .rd_stb(rd_stb), .stat_byte(stat_byte), .stat_vld(stat_vld), .busy(busy)
  );

  assign read_mode = (st == ST_READ);
endmodule

// File: tb/erase_status_ctrl_test.sv
module erase_status_ctrl_test;
  localparam int CLK_P = 10;
  localparam int WIN   = 12;
  localparam int PGM   = 5;
  localparam int ERS   = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic pgm_req = 0, pgm_msb = 0, chip_req = 0, sect_req = 0;
  logic [2:0] sect_sel = 0;
  logic other_cmd = 0, abort_req = 0, alg_fault = 0, rd_stb = 0;
  logic [7:0] stat_byte;
  logic stat_vld, busy, read_mode;
  logic [7:0] sect_mask;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] rd_val;

  always #(CLK_P/2) clk = ~clk;

  erase_status_ctrl #(.NUM_SECT(8), .WIN_CYC(WIN), .PGM_CYC(PGM), .ERASE_CYC(ERS)) uut (
    .clk(clk), .rst_n(rst_n), .pgm_req(pgm_req), .pgm_msb(pgm_msb),
    .chip_erase_req(chip_req), .sect_erase_req(sect_req), .sect_sel(sect_sel),
    .other_cmd(other_cmd), .abort_req(abort_req), .alg_fault(alg_fault),
    .rd_stb(rd_stb), .stat_byte(stat_byte), .stat_vld(stat_vld), .busy(busy),
    .sect_mask(sect_mask), .read_mode(read_mode)
  );

  // behavioural reference: 0 read, 1 window, 2 erase, 3 program, 4 fault
  int m_st, m_cnt;
  logic [7:0] m_mask, m_sb;
  bit m_d7, m_ope, m_tog, m_sv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_mask = 0; m_d7 = 0; m_ope = 0; m_tog = 0; m_sb = 0; m_sv = 0;
    end else begin
      bit any_other;
      any_other = other_cmd || pgm_req || chip_req || abort_req;
      m_sv = rd_stb && (m_st != 0);
      m_sb = 0;
      if (m_sv) begin
        m_sb[7] = (m_st == 3 || (m_st == 4 && !m_ope)) ? !m_d7 : 1'b0;
        m_sb[6] = m_tog;
        m_sb[5] = (m_st == 4);
        m_sb[3] = (m_st == 2 || (m_st == 4 && m_ope));
      end
      if (m_st == 0) m_tog = 0; else if (rd_stb) m_tog = !m_tog;
      if (m_st == 0) begin
        if (pgm_req) begin m_st = 3; m_cnt = 0; m_d7 = pgm_msb; m_ope = 0; end
        else if (chip_req) begin m_st = 2; m_cnt = 0; m_mask = 8'hFF; m_ope = 1; end
        else if (sect_req) begin m_st = 1; m_cnt = 0; m_mask = 8'd1 << sect_sel; m_ope = 1; end
      end else if (m_st == 1) begin
        if (any_other) begin m_st = 0; m_cnt = 0; m_mask = 0; end
        else if (sect_req) begin m_cnt = 0; m_mask = m_mask | (8'd1 << sect_sel); end
        else if (m_cnt == WIN - 1) begin m_st = 2; m_cnt = 0; end
        else m_cnt++;
      end else if (m_st == 2 || m_st == 3) begin
        if (alg_fault) m_st = 4;
        else if (m_cnt == ((m_st == 2) ? ERS : PGM) - 1) begin
          if (m_st == 2) m_mask = 0;
          m_st = 0; m_cnt = 0;
        end else m_cnt++;
      end else begin
        if (abort_req) begin m_st = 0; m_cnt = 0; m_mask = 0; end
      end
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R11 stat_vld", {7'd0, stat_vld}, {7'd0, m_sv});
      chk("R8 stat_byte", stat_byte, m_sb);
      chk("R5 busy", {7'd0, busy}, {7'd0, (m_st != 0)});
      chk("R2 read_mode", {7'd0, read_mode}, {7'd0, (m_st == 0)});
      chk("R3 sect_mask", sect_mask, m_mask);
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic p_sect(int s);
    sect_sel = 3'(s); sect_req = 1; @(posedge clk); #1; sect_req = 0;
  endtask
  task automatic p_pgm(bit b);
    pgm_msb = b; pgm_req = 1; @(posedge clk); #1; pgm_req = 0;
  endtask
  task automatic p_chip();
    chip_req = 1; @(posedge clk); #1; chip_req = 0;
  endtask
  task automatic p_other();
    other_cmd = 1; @(posedge clk); #1; other_cmd = 0;
  endtask
  task automatic p_abort();
    abort_req = 1; @(posedge clk); #1; abort_req = 0;
  endtask
  task automatic p_fault();
    alg_fault = 1; @(posedge clk); #1; alg_fault = 0;
  endtask
  task automatic do_read();
    rd_stb = 1; @(posedge clk); #1; rd_stb = 0; rd_val = stat_byte;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    @(posedge clk); #1 rst_n = 1;
    // R1 reset state
    chk("R1 read_mode", {7'd0, read_mode}, 8'd1);
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 mask", sect_mask, 8'h00);
    chk("R1 stat_vld", {7'd0, stat_vld}, 8'd0);

    // R7 program with msb 1, R9 toggle sequence
    p_pgm(1);
    do_read(); chk("R7 poll msb1", rd_val, 8'h00);
    do_read(); chk("R9 toggle second read", rd_val, 8'h40);
    idle(10);
    chk("R7 program done", {7'd0, read_mode}, 8'd1);
    p_pgm(0);
    do_read(); chk("R7 poll msb0", rd_val, 8'h80);
    idle(10);

    // R11 no status in read mode
    do_read();
    chk("R11 idle read vld", {7'd0, stat_vld}, 8'd0);
    chk("R11 idle read byte", rd_val, 8'h00);

    // R2 R3 batching in any order with restart
    p_sect(5);
    chk("R2 first sector", sect_mask, 8'h20);
    do_read(); chk("R8 window bit3 low", rd_val, 8'h00);
    idle(6); p_sect(2);
    idle(6); p_sect(7);
    chk("R3 mask gathered", sect_mask, 8'hA4);
    idle(8);
    do_read(); chk("R3 window restarted", rd_val, 8'h40);
    idle(14);
    do_read(); chk("R8 erase bit3 high", rd_val, 8'h08);
    p_other();
    chk("R6 busy kept", {7'd0, busy}, 8'd1);
    chk("R6 mask kept", sect_mask, 8'hA4);
    idle(25);
    chk("R5 erase done", {7'd0, read_mode}, 8'd1);
    chk("R5 mask cleared", sect_mask, 8'h00);

    // R4 cancel by other command and by program
    p_sect(1); idle(3); p_other();
    chk("R4 cancel read_mode", {7'd0, read_mode}, 8'd1);
    chk("R4 cancel mask", sect_mask, 8'h00);
    p_sect(0); p_pgm(0);
    chk("R4 program not started", {7'd0, busy}, 8'd0);

    // R5 chip erase, R6 commands ignored
    p_chip();
    chk("R5 chip mask", sect_mask, 8'hFF);
    p_abort(); p_sect(3);
    chk("R6 abort ignored", {7'd0, busy}, 8'd1);
    chk("R6 mask stable", sect_mask, 8'hFF);
    do_read(); chk("R8 chip erase status", rd_val, 8'h08);
    idle(25);
    chk("R5 chip erase done", {7'd0, read_mode}, 8'd1);

    // R10 fault during erase
    p_chip(); idle(3); p_fault();
    do_read(); chk("R10 erase fault status", rd_val, 8'h28);
    idle(30);
    chk("R10 held busy", {7'd0, busy}, 8'd1);
    do_read(); chk("R10 toggle in fault", rd_val, 8'h68);
    p_other();
    chk("R10 other ignored", {7'd0, busy}, 8'd1);
    p_abort();
    chk("R10 abort returns", {7'd0, read_mode}, 8'd1);
    chk("R10 mask cleared", sect_mask, 8'h00);

    // R10 fault during program
    p_pgm(0); p_fault();
    do_read(); chk("R10 program fault status", rd_val, 8'hA0);
    p_abort();
    chk("R10 program abort", {7'd0, read_mode}, 8'd1);

    idle(4);
    finish_run();
  end
endmodule